// File: doc/BRIEF.md
# Sixteen-Pin Configurable GPIO Port

This block controls one port of sixteen general-purpose pins. Software programs it through five word-wide registers on a small synchronous register bus. The registers hold the output latch, pin direction, a per-pin attribute and a per-pin special-function mask. For every pin the block drives a pad with a tri-state output value, an output enable and pull-up and pull-down enables. It also takes in the pad's input level.

The attribute bit has two roles, and the direction bit decides which one applies. On an input pin it chooses between a pull resistor, whose polarity comes from the latch, and a floating pad. On an output pin it chooses between inverted drive and true drive. When a mask bit is set, the pin is taken away from the GPIO logic and handed to one of two peripheral function sets. A port-level select input picks the set. The pad level read by software, and the level passed to peripherals, both go through a two-flop synchronizer.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset, all registers are 0. Every pin is then an undriven input with pull-down on, pull-up off and no special function. Register reads at offsets 1 to 4 return 0.
- R2: Register offsets are: 0 pin level / latch write, 1 latch, 2 direction, 3 attribute, 4 mask. Offsets 5 to 7 read as 0. A write to offsets 5 to 7 changes no register.
- R3: A write to offset 0 or offset 1 loads the output latch. A read at offset 1 returns the latch.
- R4: A read at offset 0 returns the pad input level as sampled two clock edges earlier.
- R5: On a pin with mask 0, the output enable equals the direction bit: 1 drives the pin, 0 leaves it an input. A driven pin never has a pull enabled.
- R6: On a mask-0 input pin with attribute 0, latch 1 enables only the pull-up and latch 0 enables only the pull-down.
- R7: On a mask-0 input pin with attribute 1, both pulls are off.
- R8: On a mask-0 output pin with attribute 0, the pad output is the inverse of the latch bit.
- R9: On a mask-0 output pin with attribute 1, the pad output equals the latch bit.
- R10: On a pin with mask 1, output value and enable come from function set A when the select input is 0 and from set B when it is 1. Both pulls are off.
- R11: The peripheral input vector carries the synchronized pad level on mask-1 pins and 0 on mask-0 pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data at reg_addr (combinational) |
| func_sel | input | 1 | Selects peripheral function set A (0) or B (1) |
| alt_a_out | input | 16 | Function set A output values |
| alt_a_oe | input | 16 | Function set A output enables |
| alt_b_out | input | 16 | Function set B output values |
| alt_b_oe | input | 16 | Function set B output enables |
| alt_in | output | 16 | Synchronized pad level on masked pins |
| pad_in | input | 16 | Pad input level |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |

## Verification
Every pad output is a combinational function of the registers. A corrupted direction, attribute, mask or latch bit therefore shows up on the pad lines in the cycle after the write. It appears as a wrong enable, a flipped polarity or a pull that is on when it should be off. A wrong synchronizer depth shows at offset 0 as a pad change that arrives one edge early or late. The stimulus mixes random register contents with random pad and peripheral values, so that every pin visits every mode combination. A broken routing term for any mode is then visible on the pads shortly after it happens.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        OFS_LEVEL = 3'd0,
        OFS_LATCH = 3'd1,
        OFS_DIR   = 3'd2,
        OFS_ATTR  = 3'd3,
        OFS_MASK  = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic latch;
        logic dir;
        logic attr;
        logic mask;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
        logic pd;
    } pad_drv_t;

    // GPIO-owned pin: attribute means polarity when driving, float when input
    function automatic pad_drv_t gpio_drive(input pin_cfg_t c);
        pad_drv_t d;
        d.oe  = c.dir;
        d.out = c.attr ? c.latch : ~c.latch;
        d.pu  = ~c.dir & ~c.attr &  c.latch;
        d.pd  = ~c.dir & ~c.attr & ~c.latch;
        return d;
    endfunction

    function automatic pad_drv_t pin_drive(input pin_cfg_t c, input logic sf_out,
                                           input logic sf_oe);
        pad_drv_t d;
        if (c.mask) begin
            d.oe  = sf_oe;
            d.out = sf_out;
            d.pu  = 1'b0;
            d.pd  = 1'b0;
        end else begin
            d = gpio_drive(c);
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      level,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      attr_q,
    output logic [W-1:0]      mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            attr_q  <= '0;
            mask_q  <= '0;
        end else if (we) begin
            case (addr)
                OFS_LEVEL, OFS_LATCH: latch_q <= wdata;
                OFS_DIR:              dir_q   <= wdata;
                OFS_ATTR:             attr_q  <= wdata;
                OFS_MASK:             mask_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_LEVEL: rdata = level;
            OFS_LATCH: rdata = latch_q;
            OFS_DIR:   rdata = dir_q;
            OFS_ATTR:  rdata = attr_q;
            OFS_MASK:  rdata = mask_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux
    import gpio_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] attr_q,
    input  logic [W-1:0] mask_q,
    input  logic         func_sel,
    input  logic [W-1:0] alt_a_out,
    input  logic [W-1:0] alt_a_oe,
    input  logic [W-1:0] alt_b_out,
    input  logic [W-1:0] alt_b_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_pd
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_cfg_t cfg;
        pad_drv_t drv;
        logic     sf_out;
        logic     sf_oe;

        assign cfg    = '{latch: latch_q[i], dir: dir_q[i], attr: attr_q[i], mask: mask_q[i]};
        assign sf_out = func_sel ? alt_b_out[i] : alt_a_out[i];
        assign sf_oe  = func_sel ? alt_b_oe[i]  : alt_a_oe[i];
        assign drv    = pin_drive(cfg, sf_out, sf_oe);

        assign pad_out[i] = drv.out;
        assign pad_oe[i]  = drv.oe;
        assign pad_pu[i]  = drv.pu;
        assign pad_pd[i]  = drv.pd;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int W          = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      rd_data,
    input  logic              func_sel,
    input  logic [W-1:0]      alt_a_out,
    input  logic [W-1:0]      alt_a_oe,
    input  logic [W-1:0]      alt_b_out,
    input  logic [W-1:0]      alt_b_oe,
    output logic [W-1:0]      alt_in,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu,
    output logic [W-1:0]      pad_pd
);

    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] attr_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] level_s;

    gpio_port_sync #(.W(W), .STAGES(SYNC_DEPTH)) sync_i (
        .clk (clk),
        .d   (pad_in),
        .q   (level_s)
    );

    gpio_port_regs #(.W(W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .level   (level_s),
        .rdata   (rd_data),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .attr_q  (attr_q),
        .mask_q  (mask_q)
    );

    gpio_port_pinmux #(.W(W)) mux_i (
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .attr_q    (attr_q),
        .mask_q    (mask_q),
        .func_sel  (func_sel),
        .alt_a_out (alt_a_out),
        .alt_a_oe  (alt_a_oe),
        .alt_b_out (alt_b_out),
        .alt_b_oe  (alt_b_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd)
    );

    assign alt_in = level_s & mask_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [2:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] rd_data,
    input logic         func_sel,
    input logic [W-1:0] alt_a_oe,
    input logic [W-1:0] alt_b_oe,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] pad_pd,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] attr_q,
    input logic [W-1:0] mask_q
);

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr <= 3'd1) |=> latch_q == $past(reg_wdata)); // R3

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd2) |=> dir_q == $past(reg_wdata)); // R2

    AST_LEVEL_DELAY: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd0) |-> rd_data == $past(pad_in, 2)); // R4

    AST_DRIVE_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & (pad_pu | pad_pd)) == '0); // R5

    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0); // R6

    AST_FLOAT_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu | pad_pd) & attr_q & ~mask_q) == '0); // R7

    AST_OUT_INVERT: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~mask_q & ~attr_q & ~(pad_out ^ latch_q)) == '0); // R8

    AST_OUT_TRUE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~mask_q & attr_q & (pad_out ^ latch_q)) == '0); // R9

    AST_SPECIAL_OE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe ^ (func_sel ? alt_b_oe : alt_a_oe)) & mask_q) == '0); // R10

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_data   (rd_data),
    .func_sel  (func_sel),
    .alt_a_oe  (alt_a_oe),
    .alt_b_oe  (alt_b_oe),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .attr_q    (attr_q),
    .mask_q    (mask_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] rd_data;
    logic        func_sel;
    logic [15:0] alt_a_out, alt_a_oe, alt_b_out, alt_b_oe, alt_in;
    logic [15:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] m_latch, m_dir, m_attr, m_mask;

    always #5 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .func_sel(func_sel),
        .alt_a_out(alt_a_out), .alt_a_oe(alt_a_oe), .alt_b_out(alt_b_out),
        .alt_b_oe(alt_b_oe), .alt_in(alt_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
        case (a)
            3'd0, 3'd1: m_latch = d;
            3'd2:       m_dir   = d;
            3'd3:       m_attr  = d;
            3'd4:       m_mask  = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [15:0] sel_out();
        return func_sel ? alt_b_out : alt_a_out;
    endfunction

    function automatic logic [15:0] sel_oe();
        return func_sel ? alt_b_oe : alt_a_oe;
    endfunction

    task automatic check_all();
        logic [15:0] v, g, inp, outp;
        g    = ~m_mask;
        inp  = g & ~m_dir;
        outp = g & m_dir;
        chk("R5 oe", pad_oe & g, m_dir & g);
        chk("R5 no pull when driven", (pad_pu | pad_pd) & m_dir & g, 16'h0);
        chk("R6 pull-up", pad_pu & inp & ~m_attr, m_latch & inp & ~m_attr);
        chk("R6 pull-down", pad_pd & inp & ~m_attr, ~m_latch & inp & ~m_attr);
        chk("R7 float", (pad_pu | pad_pd) & inp & m_attr, 16'h0);
        chk("R8 inverted", pad_out & outp & ~m_attr, ~m_latch & outp & ~m_attr);
        chk("R9 true", pad_out & outp & m_attr, m_latch & outp & m_attr);
        chk("R10 special out", pad_out & m_mask, sel_out() & m_mask);
        chk("R10 special oe", pad_oe & m_mask, sel_oe() & m_mask);
        chk("R10 special no pull", (pad_pu | pad_pd) & m_mask, 16'h0);
        chk("R11 alt_in", alt_in, pad_in & m_mask);
        rd(3'd1, v); chk("R3 latch read", v, m_latch);
        rd(3'd2, v); chk("R2 dir read", v, m_dir);
        rd(3'd3, v); chk("R2 attr read", v, m_attr);
        rd(3'd4, v); chk("R2 mask read", v, m_mask);
        rd(3'd0, v); chk("R4 level read", v, pad_in);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h1234_5678));
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        func_sel = 1'b0; alt_a_out = '0; alt_a_oe = '0; alt_b_out = '0; alt_b_oe = '0;
        pad_in = '0;
        m_latch = '0; m_dir = '0; m_attr = '0; m_mask = '0;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 oe", pad_oe, 16'h0);
        chk("R1 pu", pad_pu, 16'h0);
        chk("R1 pd", pad_pd, 16'hFFFF);
        for (int a = 1; a <= 4; a++) begin
            rd(3'(a), v); chk("R1 reg zero", v, 16'h0);
        end

        // R2 unused offsets: writes ignored, reads zero
        wr(3'd2, 16'h00F0);
        for (int a = 5; a <= 7; a++) wr(3'(a), 16'hFFFF);
        for (int a = 5; a <= 7; a++) begin
            rd(3'(a), v); chk("R2 unused read", v, 16'h0);
        end
        check_all();

        // R3 write through offset 0 and offset 1
        wr(3'd0, 16'hA5C3); rd(3'd1, v); chk("R3 latch via ofs0", v, 16'hA5C3);
        wr(3'd1, 16'h3C5A); rd(3'd1, v); chk("R3 latch via ofs1", v, 16'h3C5A);

        // R4 two-edge latency on the level read
        pad_in = 16'h0000; step(); step();
        pad_in = 16'hBEEF;
        step(); rd(3'd0, v); chk("R4 one edge old", v, 16'h0000);
        step(); rd(3'd0, v); chk("R4 two edges new", v, 16'hBEEF);

        // directed corners R6..R10
        wr(3'd4, 16'h0000); wr(3'd2, 16'h00FF); wr(3'd3, 16'h0F0F); wr(3'd0, 16'h3333);
        check_all();
        wr(3'd4, 16'hF00F); func_sel = 1'b1; alt_b_out = 16'h1234; alt_b_oe = 16'hFF00;
        alt_a_out = 16'hFFFF; alt_a_oe = 16'hFFFF;
        step();
        check_all();

        // constrained random
        for (int n = 0; n < 400; n++) begin
            wr(3'($urandom_range(0, 7)), 16'($urandom));
            if ($urandom_range(0, 3) == 0) wr(3'($urandom_range(0, 4)), 16'($urandom));
            func_sel  = 1'($urandom);
            alt_a_out = 16'($urandom); alt_a_oe = 16'($urandom);
            alt_b_out = 16'($urandom); alt_b_oe = 16'($urandom);
            pad_in    = 16'($urandom);
            step(); step();
            check_all();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule